// File: doc/BRIEF.md
# Cyclic Tag Memory Readout Sequencer

This block produces the serial bit stream that a passive tag sends back to a reader. The stream is drawn from a small memory of 32-bit words arranged as two pages of eight blocks. One output bit is produced for every pulse of a bit-clock enable. The memory sits outside the block and is reached through a synchronous read port with one cycle of latency.

Two read modes are offered. Continuous read starts at block 1 and runs up to a last block set by a 3-bit limit, then goes back to block 1. Single-block read repeats one addressed block of either page without end. Entering either mode always sends one zero bit first. On page 1, block 0 gives back the configuration word of page 0. Blocks 3 to 7 of page 1 read as all zeros, and no memory access is made for them.

The read of the next word is issued on the bit-clock pulse that sends the last bit of the current block. The new word is therefore ready for the next pulse, and no idle bits appear between blocks, even when the enable is high on every cycle.

Top module: `tag_readout`

## Requirements
- R1: After a synchronous active-high reset, `dout_o` is 0 and the block is idle. It issues no memory read until a non-idle mode is entered.
- R2: `mode_i` is sampled only in cycles where `bit_en_i` is 1. The encoding is 0 = idle, 1 = continuous, 2 = single-block, and 3 is treated as idle. When the sampled mode differs from the active one, that mode is entered. Entering continuous or single-block mode sends a 0 bit before any memory data.
- R3: In continuous mode the limit `max_blk_i` is latched on entry. The stream is block 1, block 2, and so on up to the limit, then block 1 again, with no further leading zero. All of these reads go to page 0. A change of `max_blk_i` while the mode stays the same has no effect.
- R4: With a limit of 1, continuous mode repeats block 1 of page 0.
- R5: With a limit of 0, continuous mode repeats block 0 of page 0, the configuration word.
- R6: Single-block mode latches `page_i` and `addr_i` on entry and repeats that block without end. Changes to `page_i` or `addr_i` while the mode stays the same have no effect.
- R7: A single-block read of page 1, block 0 sends the word of page 0, block 0. The memory read goes to page 0, address 0.
- R8: A single-block read of page 1, blocks 3 to 7 sends 32 zero bits per block. No memory read is issued to page 1 at address 3 or above.
- R9: Each block is sent most significant bit first, from bit 31 down to bit 0 of the stored word.
- R10: The read port has one cycle of latency: `mem_data_i` is valid only in the cycle after `mem_rd_o`. Bit 31 of the next block follows bit 0 of the previous block (or the leading zero) on the very next `bit_en_i` pulse, even when the pulses are back to back.
- R11: `dout_o` is registered. It changes only at the clock edge that closes a cycle in which `bit_en_i` is 1, and it holds its value otherwise.
- R12: A return to idle through `mode_i` forces `dout_o` to 0 and keeps it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en_i | input | 1 | Bit-clock enable, one output bit per pulse |
| mode_i | input | 2 | Requested mode: 0 idle, 1 continuous, 2 single-block, 3 idle |
| max_blk_i | input | 3 | Last block of continuous read |
| page_i | input | 1 | Page of single-block read |
| addr_i | input | 3 | Block of single-block read |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_page_o | output | 1 | Memory read page |
| mem_addr_o | output | 3 | Memory read block address |
| mem_data_i | input | 32 | Memory read data, valid the cycle after the strobe |
| dout_o | output | 1 | Serial output bit |

## Verification
Every output bit is due at the edge that closes its `bit_en_i` cycle. The bench model therefore advances only at those edges and compares `dout_o` at every falling edge, so the value is also checked between pulses. The memory model answers one cycle after `mem_rd_o` and drives junk in every other cycle. Any fetch that comes late, or any use of stale data, then shows up as a wrong bit at a block boundary. The read strobe and its page and address are combinational outputs of the cycle that issues them, and they are checked at the falling edge of that same cycle.

// File: rtl/tro_pkg.sv
package tro_pkg;
  localparam int BLK_W     = 3;
  localparam int ZERO_FROM = 3;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CONT = 2'd1,
    MODE_ONE  = 2'd2
  } mode_e;

  function automatic mode_e to_mode(input logic [1:0] m);
    case (m)
      2'd1:    return MODE_CONT;
      2'd2:    return MODE_ONE;
      default: return MODE_IDLE;
    endcase
  endfunction

  function automatic logic [BLK_W-1:0] first_block(input logic [BLK_W-1:0] lim);
    return (lim == '0) ? '0 : BLK_W'(1);
  endfunction

  function automatic logic [BLK_W-1:0] next_block(input logic [BLK_W-1:0] cur,
                                                  input logic [BLK_W-1:0] lim);
    if (lim == '0) return '0;
    if (cur >= lim) return BLK_W'(1);
    return cur + BLK_W'(1);
  endfunction

  function automatic logic is_zero_blk(input logic pg, input logic [BLK_W-1:0] blk);
    return pg && (blk >= BLK_W'(ZERO_FROM));
  endfunction

  function automatic logic phys_page(input logic pg, input logic [BLK_W-1:0] blk);
    return pg && (blk != '0);
  endfunction
endpackage

// File: rtl/tro_ctrl.sv
module tro_ctrl
  import tro_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en_i,
  input  logic [1:0]       mode_i,
  input  logic [BLK_W-1:0] max_blk_i,
  input  logic             page_i,
  input  logic [BLK_W-1:0] addr_i,
  input  logic             last_bit_i,
  output logic             enter_o,
  output logic             fetch_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             fetch_page_o,
  output logic [BLK_W-1:0] fetch_blk_o,
  output mode_e            mode_o,
  output logic [BLK_W-1:0] limit_o
);
  mode_e            mode_q;
  logic [BLK_W-1:0] limit_q;
  logic [BLK_W-1:0] blk_q;
  logic             page_q;
  logic             need_load_q;
  mode_e            req_mode;
  logic             active;

  assign req_mode = to_mode(mode_i);
  assign active   = (mode_q != MODE_IDLE);
  assign enter_o  = bit_en_i && (req_mode != mode_q);
  assign load_o   = bit_en_i && !enter_o && active && need_load_q;
  assign shift_o  = bit_en_i && !enter_o && active && !need_load_q;
  assign fetch_o  = (enter_o && (req_mode != MODE_IDLE)) || (shift_o && last_bit_i);

  always_comb begin
    if (enter_o) begin
      fetch_page_o = (req_mode == MODE_ONE) ? page_i : 1'b0;
      fetch_blk_o  = (req_mode == MODE_ONE) ? addr_i : first_block(max_blk_i);
    end else begin
      fetch_page_o = page_q;
      fetch_blk_o  = (mode_q == MODE_CONT) ? next_block(blk_q, limit_q) : blk_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_IDLE;
      limit_q     <= '0;
      blk_q       <= '0;
      page_q      <= 1'b0;
      need_load_q <= 1'b0;
    end else if (enter_o) begin
      mode_q      <= req_mode;
      limit_q     <= max_blk_i;
      blk_q       <= fetch_blk_o;
      page_q      <= fetch_page_o;
      need_load_q <= (req_mode != MODE_IDLE);
    end else if (fetch_o) begin
      blk_q       <= fetch_blk_o;
      need_load_q <= 1'b1;
    end else if (load_o) begin
      need_load_q <= 1'b0;
    end
  end

  assign mode_o  = mode_q;
  assign limit_o = limit_q;
endmodule

// File: rtl/tro_fetch.sv
module tro_fetch
  import tro_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_i,
  input  logic              load_i,
  input  logic              fetch_page_i,
  input  logic [BLK_W-1:0]  fetch_blk_i,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              mem_rd_o,
  output logic              mem_page_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0] word_o,
  output logic              pend_o,
  output logic              buf_valid_o
);
  logic              pend_q;
  logic              zpend_q;
  logic              buf_valid_q;
  logic [WORD_W-1:0] buf_q;
  logic              zero_w;
  logic [WORD_W-1:0] arrived_w;

  assign zero_w     = is_zero_blk(fetch_page_i, fetch_blk_i);
  assign mem_rd_o   = fetch_i && !zero_w;
  assign mem_page_o = phys_page(fetch_page_i, fetch_blk_i);
  assign mem_addr_o = fetch_blk_i;

  assign arrived_w  = zpend_q ? '0 : mem_data_i;
  assign word_o     = pend_q ? arrived_w : buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      zpend_q     <= 1'b0;
      buf_valid_q <= 1'b0;
      buf_q       <= '0;
    end else begin
      pend_q  <= fetch_i;
      zpend_q <= fetch_i && zero_w;
      if (pend_q) buf_q <= arrived_w;
      if (load_i)      buf_valid_q <= 1'b0;
      else if (pend_q) buf_valid_q <= 1'b1;
    end
  end

  assign pend_o      = pend_q;
  assign buf_valid_o = buf_valid_q;
endmodule

// File: rtl/tro_shift.sv
module tro_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              dout_o,
  output logic              last_bit_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_NEXT = IDX_W'(WORD_W - 2);

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      idx_q  <= IDX_TOP;
      dout_q <= 1'b0;
    end else if (enter_i) begin
      dout_q <= 1'b0;
    end else if (load_i) begin
      dout_q <= word_i[WORD_W-1];
      word_q <= word_i;
      idx_q  <= IDX_NEXT;
    end else if (shift_i) begin
      dout_q <= word_q[idx_q];
      idx_q  <= (idx_q == '0) ? IDX_TOP : idx_q - IDX_W'(1);
    end
  end

  assign dout_o     = dout_q;
  assign last_bit_o = (idx_q == '0);
endmodule

// File: rtl/tag_readout.sv
module tag_readout
  import tro_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en_i,
  input  logic [1:0]        mode_i,
  input  logic [BLK_W-1:0]  max_blk_i,
  input  logic              page_i,
  input  logic [BLK_W-1:0]  addr_i,
  output logic              mem_rd_o,
  output logic              mem_page_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              dout_o
);
  logic              enter_w;
  logic              fetch_w;
  logic              load_w;
  logic              shift_w;
  logic              last_bit_w;
  logic              fetch_page_w;
  logic [BLK_W-1:0]  fetch_blk_w;
  logic [WORD_W-1:0] word_w;
  logic              pend_w;
  logic              buf_valid_w;
  mode_e             mode_w;
  logic [BLK_W-1:0]  limit_w;

  tro_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bit_en_i(bit_en_i), .mode_i(mode_i),
    .max_blk_i(max_blk_i), .page_i(page_i), .addr_i(addr_i),
    .last_bit_i(last_bit_w), .enter_o(enter_w), .fetch_o(fetch_w),
    .load_o(load_w), .shift_o(shift_w), .fetch_page_o(fetch_page_w),
    .fetch_blk_o(fetch_blk_w), .mode_o(mode_w), .limit_o(limit_w)
  );

  tro_fetch #(.WORD_W(WORD_W)) u_fetch (
    .clk(clk), .rst(rst), .fetch_i(fetch_w), .load_i(load_w),
    .fetch_page_i(fetch_page_w), .fetch_blk_i(fetch_blk_w),
    .mem_data_i(mem_data_i), .mem_rd_o(mem_rd_o), .mem_page_o(mem_page_o),
    .mem_addr_o(mem_addr_o), .word_o(word_w), .pend_o(pend_w),
    .buf_valid_o(buf_valid_w)
  );

  tro_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .enter_i(enter_w), .load_i(load_w),
    .shift_i(shift_w), .word_i(word_w), .dout_o(dout_o),
    .last_bit_o(last_bit_w)
  );
endmodule

// File: rtl/tro_chk.sv
module tro_chk
  import tro_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bit_en_i,
  input logic             dout_o,
  input logic             mem_rd_o,
  input logic             mem_page_o,
  input logic [BLK_W-1:0] mem_addr_o,
  input logic             enter_w,
  input logic             load_w,
  input logic             pend_w,
  input logic             buf_valid_w,
  input mode_e            mode_w,
  input logic [BLK_W-1:0] limit_w
);
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode_w == MODE_IDLE && !enter_w) |-> !mem_rd_o); // R1

  AST_ENTRY_ZERO: assert property (@(posedge clk) disable iff (rst)
    enter_w |=> !dout_o); // R2

  AST_CONT_PAGE0: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && mode_w == MODE_CONT && !enter_w) |-> !mem_page_o); // R3

  AST_LIMIT0_CFG: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && mode_w == MODE_CONT && !enter_w && limit_w == '0) |-> (mem_addr_o == '0)); // R5

  AST_PAGE1_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && mem_page_o) |-> (mem_addr_o == 3'd1 || mem_addr_o == 3'd2)); // R8

  AST_LOAD_READY: assert property (@(posedge clk) disable iff (rst)
    load_w |-> (pend_w || buf_valid_w)); // R10

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bit_en_i)) |-> $stable(dout_o)); // R11

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode_w == MODE_IDLE) |-> !dout_o); // R12
endmodule

bind tag_readout tro_chk u_chk (
  .clk(clk), .rst(rst), .bit_en_i(bit_en_i), .dout_o(dout_o),
  .mem_rd_o(mem_rd_o), .mem_page_o(mem_page_o), .mem_addr_o(mem_addr_o),
  .enter_w(enter_w), .load_w(load_w), .pend_w(pend_w),
  .buf_valid_w(buf_valid_w), .mode_w(mode_w), .limit_w(limit_w)
);

// File: tb/sim_tag_readout.sv
module sim_tag_readout;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [2:0]  max_blk = 3'd0;
  logic        page = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        mem_rd;
  logic        mem_page;
  logic [2:0]  mem_addr;
  logic [31:0] mem_data = 32'h0;
  logic        dout;

  logic [31:0] mem [2][8];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R1";
  logic done = 1'b0;

  // reference state
  int emode = 0, elim = 0, epg = 0, eblk = 0, epos = 31;
  logic exp_bit = 1'b0;

  always #2 clk = ~clk;

  tag_readout u0 (
    .clk(clk), .rst(rst), .bit_en_i(bit_en), .mode_i(mode),
    .max_blk_i(max_blk), .page_i(page), .addr_i(addr),
    .mem_rd_o(mem_rd), .mem_page_o(mem_page), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .dout_o(dout)
  );

  function automatic logic [31:0] wexp(input int pg, input int b);
    if (pg == 1 && b == 0) return mem[0][0];
    if (pg == 1 && b >= 3) return 32'h0;
    return mem[pg][b];
  endfunction

  // memory with one cycle latency, junk otherwise
  always @(posedge clk) begin
    if (mem_rd) mem_data <= mem[mem_page][mem_addr];
    else        mem_data <= 32'hC3A5_0000 ^ cyc;
  end

  // behavioural reference, advances at bit-enable edges
  always @(posedge clk) begin
    int m;
    cyc <= cyc + 1;
    m = (mode == 2'd3) ? 0 : int'(mode);
    if (rst) begin
      emode = 0; exp_bit = 1'b0;
    end else if (bit_en) begin
      if (m != emode) begin
        emode = m; exp_bit = 1'b0; epos = 31;
        if (m == 1) begin elim = int'(max_blk); epg = 0; eblk = (elim == 0) ? 0 : 1; end
        if (m == 2) begin epg = int'(page); eblk = int'(addr); end
      end else if (emode != 0) begin
        logic [31:0] w;
        w = wexp(epg, eblk);
        exp_bit = w[epos];
        if (epos == 0) begin
          epos = 31;
          if (emode == 1) eblk = (elim == 0) ? 0 : (eblk % elim) + 1;
        end else epos = epos - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (dout !== exp_bit) begin
        fails++;
        $display("FAIL %s dout=%0b expected %0b at cycle %0d", tag, dout, exp_bit, cyc);
      end
      if (emode == 0 && !(bit_en && mode != 2'd0 && mode != 2'd3)) begin
        checks++;
        if (mem_rd !== 1'b0) begin
          fails++;
          $display("FAIL R1 mem_rd=%0b expected 0 while idle", mem_rd);
        end
      end
      if (mem_rd) begin
        checks++;
        if (mem_page && mem_addr >= 3'd3) begin
          fails++;
          $display("FAIL R8 read page=%0d addr=%0d expected no read", mem_page, mem_addr);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_bits(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  initial begin
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 8; b++)
        mem[p][b] = (p * 8 + b + 1) * 32'h9E37_79B1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset, enables with idle mode
    tag = "R1";
    run_bits(10, 1);
    // R3 R9 R10: continuous, limit 5, back-to-back enables
    tag = "R3 R9 R10";
    mode = 2'd1; max_blk = 3'd5;
    run_bits(420, 0);
    // R3: limit change without mode change is ignored
    max_blk = 3'd2;
    run_bits(200, 0);
    // R12: back to idle
    tag = "R12";
    mode = 2'd0;
    run_bits(40, 0);
    // R2 R11: re-entry with sparse enables, limit 2
    tag = "R2 R11";
    mode = 2'd1;
    run_bits(150, 2);
    // R4: limit 1
    tag = "R4";
    mode = 2'd0; run_bits(2, 0);
    max_blk = 3'd1; mode = 2'd1;
    run_bits(100, 1);
    // R5: limit 0 exposes configuration word
    tag = "R5";
    mode = 2'd3; run_bits(2, 0);
    max_blk = 3'd0; mode = 2'd1;
    run_bits(100, 0);
    // R6: single block page 0 block 4, direct switch from continuous
    tag = "R6";
    page = 1'b0; addr = 3'd4; mode = 2'd2;
    run_bits(50, 0);
    addr = 3'd6; page = 1'b1;
    run_bits(80, 1);
    // R7: page 1 block 0 aliases configuration, then page 1 block 2
    tag = "R7";
    mode = 2'd0; run_bits(1, 0);
    page = 1'b1; addr = 3'd0; mode = 2'd2;
    run_bits(80, 0);
    mode = 2'd0; run_bits(1, 0);
    addr = 3'd2; mode = 2'd2;
    run_bits(80, 0);
    // R8: page 1 block 5 reads zeros
    tag = "R8";
    mode = 2'd0; run_bits(1, 0);
    addr = 3'd5; mode = 2'd2;
    run_bits(80, 0);
    // R1: reset in the middle of a continuous run
    tag = "R1";
    mode = 2'd1; max_blk = 3'd7;
    run_bits(60, 0);
    rst = 1'b1; repeat (2) @(negedge clk);
    rst = 1'b0; mode = 2'd0;
    run_bits(10, 0);
    // R10 R11: full cycle with irregular spacing
    tag = "R10 R11";
    mode = 2'd1; max_blk = 3'd7;
    for (int k = 0; k < 240; k++) run_bits(1, k % 4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule